// File: doc/BRIEF.md
# Constrained Counter Slot Allocator

This block hands out performance-counter slots to event codes. A requester presents an 8-bit event code. The block derives the set of slots that are wired to count that event. It takes the lowest-numbered slot in that set that is not already in use, marks that slot busy and reports its index. When none of the permitted slots is free, the block reports a failure and leaves the busy set unchanged. A separate release port returns a slot to the free pool.

Most event codes may use any slot from 2 upward. Several codes have narrower classes, and some of them fit on a single counter. Slot 0 accepts only the cycle event. Slot 1 accepts only the instruction event. Placement is strictly first-free in ascending index order inside the permitted set, and the block makes no attempt at global optimisation.

Top module: `slot_alloc`

## Requirements
- R1: Both `req_ready` and `rel_ready` are always 1. `rsp_valid` is 1 in exactly the cycle after each cycle in which `req_valid` was 1, and is 0 otherwise. In that cycle `rsp_ok` and `rsp_slot` carry the result.
- R2: Any event code not listed in R3 to R7 may use slots 2 through 9 only.
- R3: Code 0x02 may use slot 0 and slots 2 through 9.
- R4: Code 0x8C may use only slots 1 and 7.
- R5: Codes 0x01, 0x97, 0x9A and 0x9F may use only slot 7.
- R6: The codes 0x8D, 0x8E, 0x8F, 0x90, 0x93, 0x94, 0x95, 0x96, 0x98, 0x99, 0x9B, 0x9C, 0xBF, 0xC0, 0xC1, 0xC4, 0xC5, 0xC6, 0xC8, 0xCA and 0xCB may use only slots 5, 6 and 7.
- R7: Codes 0xF5, 0xF6, 0xF7 and 0xFD may use only slots 2, 4 and 6. Code 0xF8 may use only slots 2 through 7.
- R8: A successful request returns `rsp_ok`=1 and, in `rsp_slot`, the lowest-numbered slot that is both permitted and free. Bit n of `busy_o` shows slot n. The granted bit is set in `busy_o` from the same clock edge that produces the response.
- R9: When no permitted slot is free, the response carries `rsp_ok`=0 and `busy_o` does not change.
- R10: A release with `rel_slot` below 10 clears that slot's busy bit from the next edge. A release of a slot that is already free, or of an index of 10 or more, leaves `busy_o` unchanged.
- R11: When a release and a request are accepted in the same cycle, the release is applied first, so the request may be granted the slot that is being released.
- R12: Reset clears every busy bit and drives `rsp_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_code | input | 8 | Event code to place |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release accepted (always 1) |
| rel_slot | input | 4 | Slot index to free |
| rsp_valid | output | 1 | Allocation result present |
| rsp_ok | output | 1 | 1 when a slot was granted |
| rsp_slot | output | 4 | Granted slot index |
| busy_o | output | 10 | Slots currently in use, bit n for slot n |

## Verification
The block has a single register stage. A request sampled at rising edge k has its response on the `rsp_*` outputs from edge k onward, and `busy_o` shows the grant or the release from that same edge. The bench raises each stimulus at a falling edge and lowers it at the next falling edge, so exactly one rising edge samples it. It reads the response and `busy_o` at that second falling edge. A bench-side model of the busy set is advanced once per operation, and every response is compared against it. One extra idle cycle confirms that `rsp_valid` lasts exactly one cycle.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

   typedef enum logic [2:0] {
      CLS_WIDE,
      CLS_CYCLE,
      CLS_INSTR,
      CLS_LONE,
      CLS_TRIO,
      CLS_EVEN,
      CLS_SPAN
   } aff_cls_e;

   function automatic aff_cls_e classify(input logic [7:0] code);
      aff_cls_e c;
      case (code)
         8'h02: c = CLS_CYCLE;
         8'h8C: c = CLS_INSTR;
         8'h01, 8'h97, 8'h9A, 8'h9F: c = CLS_LONE;
         8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h93, 8'h94, 8'h95, 8'h96,
         8'h98, 8'h99, 8'h9B, 8'h9C, 8'hBF, 8'hC0, 8'hC1, 8'hC4,
         8'hC5, 8'hC6, 8'hC8, 8'hCA, 8'hCB: c = CLS_TRIO;
         8'hF5, 8'hF6, 8'hF7, 8'hFD: c = CLS_EVEN;
         8'hF8: c = CLS_SPAN;
         default: c = CLS_WIDE;
      endcase
      return c;
   endfunction

   function automatic logic slot_allowed(input aff_cls_e c, input int unsigned n);
      logic r;
      case (c)
         CLS_CYCLE: r = (n == 0) || (n >= 2);
         CLS_INSTR: r = (n == 1) || (n == 7);
         CLS_LONE:  r = (n == 7);
         CLS_TRIO:  r = (n >= 5) && (n <= 7);
         CLS_EVEN:  r = (n == 2) || (n == 4) || (n == 6);
         CLS_SPAN:  r = (n >= 2) && (n <= 7);
         default:   r = (n >= 2);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/slot_affinity.sv
module slot_affinity
   import slot_alloc_pkg::*;
#(
   parameter int NUM_SLOTS = 10,
   parameter int CODE_W    = 8
) (
   input  logic [CODE_W-1:0]    code,
   output logic [NUM_SLOTS-1:0] mask
);
   aff_cls_e cls;

   assign cls = classify(code);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
      assign mask[i] = slot_allowed(cls, i);
   end
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
   parameter int NUM_SLOTS = 10,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0] cand,
   output logic                 found,
   output logic [IDX_W-1:0]     idx,
   output logic [NUM_SLOTS-1:0] grant
);
   assign found = |cand;
   assign grant = cand & (~cand + NUM_SLOTS'(1));

   always_comb begin
      idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (cand[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
   parameter int NUM_SLOTS = 10,
   parameter int CODE_W    = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [CODE_W-1:0]    req_code,
   input  logic                 rel_valid,
   output logic                 rel_ready,
   input  logic [IDX_W-1:0]     rel_slot,
   output logic                 rsp_valid,
   output logic                 rsp_ok,
   output logic [IDX_W-1:0]     rsp_slot,
   output logic [NUM_SLOTS-1:0] busy_o
);
   if (NUM_SLOTS < 8) begin : g_chk_slots
      $error("slot_alloc: NUM_SLOTS must be at least 8");
   end
   if (CODE_W != 8) begin : g_chk_code
      $error("slot_alloc: CODE_W must be 8");
   end

   logic [NUM_SLOTS-1:0] aff_mask;
   logic [NUM_SLOTS-1:0] rel_clr;
   logic [NUM_SLOTS-1:0] busy_eff;
   logic [NUM_SLOTS-1:0] cand;
   logic [NUM_SLOTS-1:0] grant;
   logic [IDX_W-1:0]     pick_idx;
   logic                 pick_found;
   logic                 rel_hit;

   logic [NUM_SLOTS-1:0] busy_q;
   logic                 rsp_valid_q;
   logic                 rsp_ok_q;
   logic [IDX_W-1:0]     rsp_slot_q;

   assign req_ready = 1'b1;
   assign rel_ready = 1'b1;

   slot_affinity #(.NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W)) u_aff (
      .code (req_code),
      .mask (aff_mask)
   );

   assign rel_hit = rel_valid && ({1'b0, rel_slot} < (IDX_W+1)'(NUM_SLOTS));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rel
      assign rel_clr[i] = rel_hit && (rel_slot == IDX_W'(i));
   end

   // release takes effect before the request looks at the free set
   assign busy_eff = busy_q & ~rel_clr;
   assign cand     = aff_mask & ~busy_eff;

   slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
      .cand  (cand),
      .found (pick_found),
      .idx   (pick_idx),
      .grant (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_ok_q    <= 1'b0;
         rsp_slot_q  <= '0;
      end else begin
         rsp_valid_q <= req_valid;
         if (req_valid) begin
            rsp_ok_q   <= pick_found;
            rsp_slot_q <= pick_found ? pick_idx : '0;
            busy_q     <= pick_found ? (busy_eff | grant) : busy_eff;
         end else begin
            busy_q     <= busy_eff;
         end
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_ok    = rsp_ok_q;
   assign rsp_slot  = rsp_slot_q;
   assign busy_o    = busy_q;
endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
   parameter int NUM_SLOTS = 10,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 rel_valid,
   input logic [IDX_W-1:0]     rel_slot,
   input logic                 rsp_valid,
   input logic                 rsp_ok,
   input logic [IDX_W-1:0]     rsp_slot,
   input logic [NUM_SLOTS-1:0] busy_o,
   input logic [NUM_SLOTS-1:0] aff_mask
);
   logic                 req_q;
   logic                 rel_any_q;
   logic                 rel_only_q;
   logic [IDX_W-1:0]     rel_slot_q;
   logic [NUM_SLOTS-1:0] busy_past;
   logic [NUM_SLOTS-1:0] aff_past;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         rel_any_q  <= 1'b0;
         rel_only_q <= 1'b0;
         rel_slot_q <= '0;
         busy_past  <= '0;
         aff_past   <= '0;
      end else begin
         req_q      <= req_valid;
         rel_any_q  <= rel_valid;
         rel_only_q <= rel_valid && !req_valid &&
                       ({1'b0, rel_slot} < (IDX_W+1)'(NUM_SLOTS));
         rel_slot_q <= rel_slot;
         busy_past  <= busy_o;
         aff_past   <= aff_mask;
      end
   end

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> rsp_valid);

   // R1
   rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_q |-> !rsp_valid);

   // R8
   grant_marked_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok) |-> busy_o[rsp_slot]);

   // R8
   grant_was_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok && !rel_any_q) |-> !busy_past[rsp_slot]);

   // R8
   grant_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok) |-> aff_past[rsp_slot]);

   // R8
   one_new_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy_o & ~busy_past) <= 1);

   // R9
   fail_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ok && !rel_any_q) |-> (busy_o == busy_past));

   // R10
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_only_q |-> !busy_o[rel_slot_q]);
endmodule

bind slot_alloc slot_alloc_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/sim_slot_alloc.sv
`timescale 1ns/1ps
module sim_slot_alloc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_code = '0;
   logic       rel_valid = 1'b0;
   logic       rel_ready;
   logic [3:0] rel_slot = '0;
   logic       rsp_valid;
   logic       rsp_ok;
   logic [3:0] rsp_slot;
   logic [9:0] busy_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [9:0] m_busy = '0;
   bit  last_ok;
   int  last_slot;

   always #4 clk = ~clk;

   slot_alloc u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
      .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_slot(rel_slot),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_slot(rsp_slot),
      .busy_o(busy_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // permitted slots per event code, written from the requirements
   function automatic logic [9:0] allow(input logic [7:0] c);
      case (c)
         8'h02: return 10'b11_1111_1101;
         8'h8C: return 10'b00_1000_0010;
         8'h01, 8'h97, 8'h9A, 8'h9F: return 10'b00_1000_0000;
         8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h93, 8'h94, 8'h95, 8'h96,
         8'h98, 8'h99, 8'h9B, 8'h9C, 8'hBF, 8'hC0, 8'hC1, 8'hC4,
         8'hC5, 8'hC6, 8'hC8, 8'hCA, 8'hCB: return 10'b00_1110_0000;
         8'hF5, 8'hF6, 8'hF7, 8'hFD: return 10'b00_0101_0100;
         8'hF8: return 10'b00_1111_1100;
         default: return 10'b11_1111_1100;
      endcase
   endfunction

   task automatic op(input bit rv, input logic [7:0] c, input bit lv,
                     input logic [3:0] s, input string tag);
      logic [9:0] mb;
      logic [9:0] cand;
      bit eok;
      int es;
      mb = m_busy;
      eok = 1'b0;
      es = 0;
      if (lv && s < 10) mb[s] = 1'b0;
      if (rv) begin
         cand = allow(c) & ~mb;
         for (int i = 9; i >= 0; i--) if (cand[i]) begin eok = 1'b1; es = i; end
         if (eok) mb[es] = 1'b1;
      end
      @(negedge clk);
      req_valid = rv; req_code = c; rel_valid = lv; rel_slot = s;
      @(negedge clk);
      req_valid = 1'b0; rel_valid = 1'b0;
      chk({tag, " rsp_valid"}, rsp_valid, rv);
      if (rv) begin
         chk({tag, " rsp_ok"}, rsp_ok, eok);
         if (eok) chk({tag, " rsp_slot"}, rsp_slot, es);
      end
      chk({tag, " busy"}, busy_o, mb);
      m_busy = mb;
      last_ok = rsp_ok;
      last_slot = rsp_slot;
   endtask

   task automatic rel(input int s);
      op(1'b0, 8'h00, 1'b1, 4'(s), "R10 release");
   endtask

   task automatic t_reset();
      chk("R12 busy after reset", busy_o, 0);
      chk("R12 rsp_valid after reset", rsp_valid, 0);
      chk("R1 req_ready", req_ready, 1);
      chk("R1 rel_ready", rel_ready, 1);
   endtask

   task automatic t_cycles();
      op(1, 8'h02, 0, 0, "R3 cycles first");
      chk("R3 cycles slot 0", last_slot, 0);
      op(1, 8'h02, 0, 0, "R3 cycles second");
      chk("R3 cycles slot 2", last_slot, 2);
      rel(0); rel(2);
   endtask

   task automatic t_instr();
      op(1, 8'h8C, 0, 0, "R4 instr a");
      chk("R4 instr slot 1", last_slot, 1);
      op(1, 8'h8C, 0, 0, "R4 instr b");
      chk("R4 instr slot 7", last_slot, 7);
      op(1, 8'h8C, 0, 0, "R9 instr full");
      chk("R9 instr fail", last_ok, 0);
      rel(1); rel(7);
   endtask

   task automatic t_lone();
      op(1, 8'h9A, 0, 0, "R5 lone");
      chk("R5 lone slot 7", last_slot, 7);
      op(1, 8'h01, 0, 0, "R9 lone full");
      chk("R9 lone fail", last_ok, 0);
      op(1, 8'h9F, 1, 7, "R11 same-cycle");
      chk("R11 regrant ok", last_ok, 1);
      chk("R11 regrant slot 7", last_slot, 7);
      rel(7);
   endtask

   task automatic t_trio();
      op(1, 8'h8D, 0, 0, "R6 trio a");
      chk("R6 trio slot 5", last_slot, 5);
      op(1, 8'hC4, 0, 0, "R6 trio b");
      chk("R6 trio slot 6", last_slot, 6);
      op(1, 8'hCB, 0, 0, "R6 trio c");
      chk("R6 trio slot 7", last_slot, 7);
      op(1, 8'h90, 0, 0, "R9 trio full");
      chk("R9 trio fail", last_ok, 0);
      rel(5); rel(6); rel(7);
   endtask

   task automatic t_even();
      op(1, 8'hF5, 0, 0, "R7 even a");
      chk("R7 even slot 2", last_slot, 2);
      op(1, 8'hF6, 0, 0, "R7 even b");
      chk("R7 even slot 4", last_slot, 4);
      op(1, 8'hFD, 0, 0, "R7 even c");
      chk("R7 even slot 6", last_slot, 6);
      op(1, 8'hF7, 0, 0, "R9 even full");
      chk("R9 even fail", last_ok, 0);
      op(1, 8'hF8, 0, 0, "R7 span");
      chk("R7 span slot 3", last_slot, 3);
      rel(2); rel(3); rel(4); rel(6);
   endtask

   task automatic t_wide();
      for (int k = 0; k < 8; k++) begin
         op(1, 8'h55, 0, 0, "R2 wide fill");
         chk("R8 wide ascending", last_slot, k + 2);
      end
      op(1, 8'h40, 0, 0, "R2 wide full");
      chk("R2 wide fail skips 0 and 1", last_ok, 0);
      for (int k = 2; k < 10; k++) rel(k);
   endtask

   task automatic t_release();
      op(1, 8'h55, 0, 0, "R10 setup");
      rel(5);
      chk("R10 free release busy", busy_o, 10'h004);
      rel(12);
      chk("R10 out-of-range release busy", busy_o, 10'h004);
      rel(2);
      chk("R10 release clears", busy_o, 0);
   endtask

   task automatic t_timing();
      op(1, 8'h02, 0, 0, "R1 timing");
      @(negedge clk);
      chk("R1 rsp_valid one cycle", rsp_valid, 0);
      rel(0);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cycles();
      t_instr();
      t_lone();
      t_trio();
      t_even();
      t_wide();
      t_release();
      t_timing();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule